// File: doc/BRIEF.md
# Dual Page Buffer Serial Access Port

This block is the serial command front end for two independent page-sized SRAM buffers. A host talks to it over a four-wire serial link in SPI mode 0 (data sampled on the rising clock edge, changed on the falling edge, most significant bit first). Each command opens with chip select going low and an opcode byte. The opcode picks the buffer and the direction. Three address bytes follow and give a starting byte offset. After that the host streams data into the chosen buffer, or streams data out of it. The byte pointer advances by one for each byte and wraps at the end of the page.

The serial pins are oversampled on the system clock, so the serial clock must run well below the system clock. The buffers are 528 bytes deep. A plain mode input selects the 512-byte binary page layout instead. The serial output has a separate enable that stands in for the high-impedance state. Transfers between the buffers and a main array are not part of this block.

Top module: `dpb_serial_port`

## Requirements
- R1: Opcode 0x84 writes buffer A and opcode 0x87 writes buffer B. Each complete data byte goes to the current offset, and the offset then advances by one.
- R2: Opcode 0xD1 reads buffer A and opcode 0xD3 reads buffer B with no dummy byte. The MSB of the first data byte appears on `so` at the falling serial clock edge that follows the last address bit.
- R3: Opcode 0xD4 reads buffer A and opcode 0xD6 reads buffer B. For these, one dummy byte follows the address, and data starts at the falling edge after the last dummy bit.
- R4: The start offset is the low 10 bits of the 24-bit address, which is sent MSB first over three bytes. In standard mode an offset of 528 or more is replaced by 0.
- R5: With `bin_page` high, only the low 9 address bits are used (bit 9 is ignored) and the page is 512 bytes long.
- R6: After the last byte of the page (527 in standard mode, 511 in binary mode), the offset wraps to 0. This applies to both reads and writes.
- R7: On a write, a byte that is only partly shifted in when chip select rises is discarded. The buffer location it would have written keeps its old value.
- R8: An unrecognised opcode keeps `so_oe` low for the rest of the transaction and writes nothing to either buffer.
- R9: `so_oe` is low after reset and whenever chip select is inactive.
- R10: Writing one buffer never changes the contents of the other buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| bin_page | input | 1 | High selects the 512-byte binary page layout |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
Each serial pin passes through two synchronizer flops and one edge register. A read bit therefore reaches `so` on the third system clock edge after the falling `sck` that launches it. A write takes effect in the buffer on the third edge after the rising `sck` that carries its last bit. The bench holds each half period of `sck` for four system clocks and samples `so` and `so_oe` on the last of those four, just before it raises `sck`. That leaves a margin of one clock over the three-clock latency. When chip select is released, the bench waits several clocks before the next check, so that the end of the transaction has reached the state that follows.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [2:0] {
    ST_OPC, ST_ADR, ST_WR, ST_DUM, ST_RD, ST_IGN
  } dpb_state_t;

  localparam logic [7:0] OP_WR_A   = 8'h84;
  localparam logic [7:0] OP_WR_B   = 8'h87;
  localparam logic [7:0] OP_RD_A   = 8'hD1;
  localparam logic [7:0] OP_RD_B   = 8'hD3;
  localparam logic [7:0] OP_RDD_A  = 8'hD4;
  localparam logic [7:0] OP_RDD_B  = 8'hD6;
endpackage

// File: rtl/dpb_pin_sync.sv
module dpb_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_s
);
  logic [2:0] sck_q;
  logic [1:0] cs_q;
  logic [1:0] si_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[0], cs_n};
      si_q  <= {si_q[0], si};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_act   = ~cs_q[1];
  assign si_s     = si_q[1];
endmodule

// File: rtl/dpb_page_ram.sv
module dpb_page_ram #(
  parameter int DEPTH = 528,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dpb_serial_port.sv
module dpb_serial_port #(
  parameter int BUF_BYTES = 528,
  parameter int BIN_BYTES = 512,
  parameter int NBUF      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bin_page,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);
  import dpb_pkg::*;

  localparam int PW = $clog2(BUF_BYTES);
  localparam int SW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam logic [PW-1:0] LAST_STD = PW'(BUF_BYTES - 1);
  localparam logic [PW-1:0] LAST_BIN = PW'(BIN_BYTES - 1);

  logic sck_rise, sck_fall, cs_act, si_s;

  dpb_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .si_s(si_s)
  );

  dpb_state_t    st;
  logic [2:0]    bitc;
  logic [6:0]    shin;
  logic [1:0]    adrc;
  logic [1:0]    adr_hi;
  logic [SW-1:0] sel;
  logic          is_wr, has_dum;
  logic [PW-1:0] ptr;
  logic [2:0]    obit;
  logic [6:0]    osh;
  logic          so_q, oe_q;

  logic [7:0]    new_byte;
  logic          byte_done;
  logic [PW-1:0] ptr_last, ptr_next, off_raw, off_start;
  logic [NBUF-1:0] we_vec;
  logic [7:0]    rd_q [NBUF];
  logic [7:0]    rd_byte;

  assign new_byte  = {shin, si_s};
  assign byte_done = sck_rise && (bitc == 3'd7);
  assign ptr_last  = bin_page ? LAST_BIN : LAST_STD;
  assign ptr_next  = (ptr == ptr_last) ? '0 : ptr + 1'b1;
  assign off_raw   = bin_page ? {1'b0, adr_hi[0], new_byte}
                              : {adr_hi, new_byte};
  assign off_start = (off_raw > ptr_last) ? '0 : off_raw;
  assign rd_byte   = rd_q[sel];

  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_buf
      assign we_vec[g] = byte_done && (st == ST_WR) && (sel == SW'(g));
      dpb_page_ram #(.DEPTH(BUF_BYTES), .AW(PW)) u_ram (
        .clk(clk), .we(we_vec[g]), .waddr(ptr), .wdata(new_byte),
        .raddr(ptr), .rdata(rd_q[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; bitc <= '0; shin <= '0; adrc <= '0; adr_hi <= '0;
      sel <= '0; is_wr <= 1'b0; has_dum <= 1'b0; ptr <= '0;
      obit <= '0; osh <= '0; so_q <= 1'b0; oe_q <= 1'b0;
    end else if (!cs_act) begin
      st <= ST_OPC; bitc <= '0; adrc <= '0; obit <= '0; oe_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        bitc <= bitc + 1'b1;
        shin <= new_byte[6:0];
        if (bitc == 3'd7) begin
          unique case (st)
            ST_OPC: begin
              st <= ST_ADR;
              unique case (new_byte)
                OP_WR_A:  begin sel <= SW'(0); is_wr <= 1'b1; has_dum <= 1'b0; end
                OP_WR_B:  begin sel <= SW'(1); is_wr <= 1'b1; has_dum <= 1'b0; end
                OP_RD_A:  begin sel <= SW'(0); is_wr <= 1'b0; has_dum <= 1'b0; end
                OP_RD_B:  begin sel <= SW'(1); is_wr <= 1'b0; has_dum <= 1'b0; end
                OP_RDD_A: begin sel <= SW'(0); is_wr <= 1'b0; has_dum <= 1'b1; end
                OP_RDD_B: begin sel <= SW'(1); is_wr <= 1'b0; has_dum <= 1'b1; end
                default:  st <= ST_IGN;
              endcase
            end
            ST_ADR: begin
              adrc   <= adrc + 1'b1;
              adr_hi <= new_byte[1:0];
              if (adrc == 2'd2) begin
                ptr <= off_start;
                st  <= is_wr ? ST_WR : (has_dum ? ST_DUM : ST_RD);
              end
            end
            ST_WR:  ptr <= ptr_next;
            ST_DUM: st  <= ST_RD;
            default: ;
          endcase
        end
      end
      if (sck_fall && st == ST_RD) begin
        oe_q <= 1'b1;
        obit <= obit + 1'b1;
        if (obit == 3'd0) begin
          so_q <= rd_byte[7];
          osh  <= rd_byte[6:0];
          ptr  <= ptr_next;
        end else begin
          so_q <= osh[6];
          osh  <= {osh[5:0], 1'b0};
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;
endmodule

// File: rtl/dpb_serial_port_chk.sv
module dpb_serial_port_chk #(
  parameter int PW   = 10,
  parameter int NBUF = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_act,
  input logic [2:0]      st,
  input logic            so_oe,
  input logic [NBUF-1:0] we_vec,
  input logic [PW-1:0]   ptr,
  input logic [PW-1:0]   ptr_last
);
  // R9: output enable drops once chip select is inactive
  assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_oe);

  // R8: an ignored transaction never drives the output
  assert_ign_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |-> !so_oe);

  // R10: at most one buffer written per cycle
  assert_one_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  // R6: pointer stays inside the page
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= ptr_last);

  // R2: output is only enabled during the read data phase
  assert_oe_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> (st == 3'd4));
endmodule

bind dpb_serial_port dpb_serial_port_chk #(.PW(PW), .NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .st(st), .so_oe(so_oe),
  .we_vec(we_vec), .ptr(ptr), .ptr_last(ptr_last)
);

// File: tb/tb_dpb_serial_port.sv
module tb_dpb_serial_port;
  logic clk = 1'b0, rst_n = 1'b0, bin_page = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [2][528];
  logic [7:0] exp_q [$];
  logic oe_seen;

  always #2 clk = ~clk;

  dpb_serial_port dut (.clk(clk), .rst_n(rst_n), .bin_page(bin_page),
    .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = tx[i];
      wait_clk(4);
      rx = {rx[6:0], so};
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; oe_seen = 1'b0; wait_clk(4);
  endtask

  task automatic cs_hi();
    wait_clk(2); cs_n = 1'b1; wait_clk(8);
  endtask

  function automatic int eff(input int off);
    int o = bin_page ? (off & 511) : (off & 1023);
    int d = bin_page ? 512 : 528;
    return (o >= d) ? 0 : o;
  endfunction

  task automatic send_hdr(input logic [7:0] op, input int adr);
    logic [7:0] r;
    spi_bits(op, 8, r);
    spi_bits(8'(adr >> 16), 8, r);
    spi_bits(8'(adr >> 8), 8, r);
    spi_bits(8'(adr), 8, r);
  endtask

  task automatic wr(input int b, input int adr, input int n, input logic [7:0] seed);
    logic [7:0] r;
    int p = eff(adr), d = bin_page ? 512 : 528;
    cs_lo();
    send_hdr(b ? 8'h87 : 8'h84, adr);
    for (int i = 0; i < n; i++) begin
      spi_bits(seed + 8'(i), 8, r);
      mdl[b][p] = seed + 8'(i);
      p = (p == d - 1) ? 0 : p + 1;
    end
    cs_hi();
  endtask

  // driver pushes expected bytes; monitor pops them as bytes arrive
  task automatic rd(input string req, input logic [7:0] op, input int adr, input int n);
    logic [7:0] r;
    int b = (op == 8'hD3 || op == 8'hD6) ? 1 : 0;
    int p = eff(adr), d = bin_page ? 512 : 528;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl[b][p]);
      p = (p == d - 1) ? 0 : p + 1;
    end
    cs_lo();
    send_hdr(op, adr);
    if (op == 8'hD4 || op == 8'hD6) spi_bits(8'h00, 8, r);
    for (int i = 0; i < n; i++) begin
      spi_bits(8'h00, 8, r);
      chk(req, r, exp_q.pop_front());
    end
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    wait_clk(3);
    chk("R9 reset oe", so_oe, 0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R9 idle oe", so_oe, 0);

    wr(0, 5, 6, 8'h10);                 // R1 buffer A
    rd("R2 D1 buf A", 8'hD1, 5, 6);
    wr(1, 5, 4, 8'hA0);                 // R1 buffer B
    rd("R2 D3 buf B", 8'hD3, 5, 4);
    rd("R10 buf A intact", 8'hD1, 5, 6);
    rd("R3 D4 dummy A", 8'hD4, 6, 3);
    rd("R3 D6 dummy B", 8'hD6, 5, 4);
    chk("R9 oe after read", so_oe, 0);

    wr(0, 526, 4, 8'h50);               // R6 write wrap 526,527,0,1
    rd("R6 read wrap", 8'hD1, 527, 3);
    rd("R6 wrap landed at 0", 8'hD4, 0, 2);

    wr(1, 24'hFC0000 | 600, 2, 8'h77);  // R4 out-of-range offset -> 0
    rd("R4 offset>=528 to 0", 8'hD3, 0, 2);

    wr(0, 100, 3, 8'h30);
    cs_lo();                            // R7 two full bytes plus 5 bits
    send_hdr(8'h84, 100);
    spi_bits(8'hC1, 8, r); mdl[0][100] = 8'hC1;
    spi_bits(8'hC2, 8, r); mdl[0][101] = 8'hC2;
    spi_bits(8'hEE, 5, r);
    cs_hi();
    rd("R7 partial discarded", 8'hD1, 100, 3);

    cs_lo();                            // R8 unknown opcode
    send_hdr(8'h55, 0);
    spi_bits(8'hD1, 8, r);
    spi_bits(8'h99, 8, r);
    spi_bits(8'h99, 8, r);
    chk("R8 oe stays low", oe_seen, 0);
    cs_hi();
    rd("R8 nothing written", 8'hD1, 0, 2);

    bin_page = 1'b1;
    wait_clk(4);
    wr(1, 510, 3, 8'h61);               // R5 binary wrap 510,511,0
    rd("R5 bin wrap", 8'hD3, 510, 3);
    wr(0, 24'h000203, 2, 8'h81);        // R5 bit 9 ignored -> offset 3
    rd("R5 bit9 ignored", 8'hD1, 3, 2);
    bin_page = 1'b0;
    wait_clk(4);
    rd("R6 std read wraps", 8'hD6, 526, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule